// File: doc/BRIEF.md
# Sampling Converter Host Bus Controller

This block sits between a processor bus and the sequencer of a successive-approximation converter. It decodes five control lines: chip enable (active high), chip select (active low), read/convert, byte address and word-width select. From them it issues a one-clock conversion start strobe and a latched length select for the sequencer. It also drives the 12-bit result onto a data bus, which is modelled as a data vector plus per-bit output enables.

A conversion starts on the transition that completes the start condition, whichever of the three start lines moves last. The byte-address line has two roles. At the start it is captured as the length select. During a read it picks which half of the result appears when the bus is read as bytes, in a left-justified split format.

The same logic serves a stand-alone setup in which only read/convert toggles. In that setup select and byte address are held low, and enable and width select are held high.

The five control lines are asynchronous and pass through a synchronizer before use. The busy status comes from the sequencer in the block's own clock domain and is used directly.

Top module: `adc_bus_ctrl`

## Requirements
- R1: `start_pulse` is high for exactly one clock when `chip_en`=1, `chip_sel_n`=0 and `rd_conv`=0 become true together. It fires on the transition of whichever of the three completes that condition last.
- R2: Several start lines changing in the same clock produce exactly one `start_pulse`.
- R3: `short_len` takes the synchronized `byte_addr` on each transition into the start condition: 1 means an 8-bit conversion and 0 a 12-bit one. Changes of `byte_addr` at any other time leave it unchanged.
- R4: While `busy`=1 a transition into the start condition gives no `start_pulse`, but `short_len` still captures `byte_addr`.
- R5: `data_oe` is all zero unless `rd_conv`=1, `busy`=0, `chip_en`=1 and `chip_sel_n`=0. Every `data_out` bit whose enable is 0 is 0.
- R6: With `wide_rd`=1 a read enables all 12 lanes (`data_oe`=12'hFFF) with `data_out`=`conv_word`, whatever `byte_addr` is.
- R7: With `wide_rd`=0 and `byte_addr`=0, `data_oe`=12'hFF0 and lanes 11..4 carry `conv_word[11:4]`.
- R8: With `wide_rd`=0 and `byte_addr`=1, `data_oe`=12'hFF0. Lanes 11..8 carry `conv_word[3:0]` and lanes 7..4 are forced to 0, so the low lanes 3..0 are never enabled by a split read.
- R9: In stand-alone use (`chip_sel_n`=0, `byte_addr`=0, `chip_en`=1, `wide_rd`=1), a falling `rd_conv` starts a 12-bit conversion. The full word is enabled whenever `rd_conv`=1 and `busy`=0.
- R10: Control inputs pass two synchronizer flops, so a change driven between clock edges first shows on the outputs after the third rising edge. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| chip_sel_n | input | 1 | Chip select, active low |
| rd_conv | input | 1 | 1 = read, 0 = convert |
| byte_addr | input | 1 | Length select at start, byte select on read |
| wide_rd | input | 1 | 1 = read all 12 bits, 0 = split bytes |
| busy | input | 1 | Converter busy status from the sequencer |
| conv_word | input | 12 | Conversion result from the sequencer |
| start_pulse | output | 1 | One-clock conversion start strobe |
| short_len | output | 1 | Latched length select, 1 = 8-bit |
| data_out | output | 12 | Data bus value |
| data_oe | output | 12 | Per-lane output enable |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a 12-bit word and 8-bit byte lanes. This makes the 4-lane zero pad of the low byte visible, and it fixes the output latency at three edges, which the bench checks edge by edge. Every ordering of the three start lines is driven, including all three changing at once. A scoreboard matches each strobe against the length select expected for it, so an extra or missing strobe is caught as well as a wrong length.

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 12,
  parameter int LANE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              chip_sel_n,
  input  logic              rd_conv,
  input  logic              byte_addr,
  input  logic              wide_rd,
  input  logic              busy,
  input  logic [WORD_W-1:0] conv_word,
  output logic              start_pulse,
  output logic              short_len,
  output logic [WORD_W-1:0] data_out,
  output logic [WORD_W-1:0] data_oe
);

  localparam int NCTL  = 5;
  localparam int LO_W  = WORD_W - LANE_W;
  localparam int PAD_W = LANE_W - LO_W;
  localparam logic [WORD_W-1:0] HI_MASK = {{LANE_W{1'b1}}, {LO_W{1'b0}}};

  logic [NCTL-1:0] sync_q [SYNC_STAGES];
  logic [NCTL-1:0] ctl;
  logic            arm, arm_d, arm_rise, rd_ok;
  logic [WORD_W-1:0] oe_n, out_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {wide_rd, byte_addr, rd_conv, chip_sel_n, chip_en};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign ctl      = sync_q[SYNC_STAGES-1];
  assign arm      = ctl[0] & ~ctl[1] & ~ctl[2];
  assign arm_rise = arm & ~arm_d;
  assign rd_ok    = ctl[2] & ~busy & ctl[0] & ~ctl[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_d       <= 1'b0;
      start_pulse <= 1'b0;
      short_len   <= 1'b0;
    end else begin
      arm_d       <= arm;
      start_pulse <= arm_rise & ~busy;
      if (arm_rise) short_len <= ctl[3];
    end
  end

  always_comb begin
    oe_n  = '0;
    out_n = '0;
    if (rd_ok) begin
      if (ctl[4]) begin
        oe_n  = '1;
        out_n = conv_word;
      end else if (!ctl[3]) begin
        oe_n  = HI_MASK;
        out_n = {conv_word[WORD_W-1 -: LANE_W], {LO_W{1'b0}}};
      end else begin
        oe_n  = HI_MASK;
        out_n = {conv_word[LO_W-1:0], {PAD_W{1'b0}}, {LO_W{1'b0}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_oe  <= '0;
      data_out <= '0;
    end else begin
      data_oe  <= oe_n;
      data_out <= out_n;
    end
  end

  // R1
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  // R4
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> !$past(busy));
  // R5
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|data_oe) |-> !$past(busy));
  // R5
  quiet_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_out & ~data_oe) == '0);
  // R8
  low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe[LO_W-1:0] != '0) |-> (&data_oe));

endmodule

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, csn = 1'b1, rc = 1'b1, a0 = 1'b0, w12 = 1'b1, bz = 1'b0;
  logic [11:0] word = 12'hA5C;
  logic start_pulse, short_len;
  logic [11:0] data_out, data_oe;
  int total = 0, bad = 0;
  bit done = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  adc_bus_ctrl i_adc_bus_ctrl (
    .clk(clk), .rst_n(rst_n), .chip_en(ce), .chip_sel_n(csn), .rd_conv(rc),
    .byte_addr(a0), .wide_rd(w12), .busy(bz), .conv_word(word),
    .start_pulse(start_pulse), .short_len(short_len),
    .data_out(data_out), .data_oe(data_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic e, input logic s, input logic r,
                       input logic a, input logic w, input logic b);
    @(negedge clk);
    ce = e; csn = s; rc = r; a0 = a; w12 = w; bz = b;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic step(input logic e, input logic s, input logic r,
                      input logic a, input logic w, input logic b);
    drive(e, s, r, a, w, b);
    settle();
  endtask

  task automatic drained(input string req);
    chk(req, exp_q.size(), 0);
  endtask

  // scoreboard monitor: every strobe must match a pushed expected length
  always @(negedge clk) begin
    if (rst_n && start_pulse) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R1 R4 unexpected start actual=1 expected=0");
      end else begin
        bit e;
        e = exp_q.pop_front();
        if (short_len !== e) begin
          bad++;
          $display("FAIL R3 short_len actual=%b expected=%b", short_len, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R10 reset state
    chk("R10 oe", data_oe, 0);
    chk("R10 start", start_pulse, 0);
    chk("R10 len", short_len, 0);

    // R1 enable rises last, 12-bit
    step(0, 0, 0, 0, 1, 0);
    drained("R1 no start without enable");
    exp_q.push_back(1'b0);
    step(1, 0, 0, 0, 1, 0);
    drained("R1 enable last");
    step(1, 0, 1, 0, 1, 0);

    // R1 select falls last, 8-bit
    step(1, 1, 0, 1, 1, 0);
    exp_q.push_back(1'b1);
    step(1, 0, 0, 1, 1, 0);
    drained("R1 select last");
    step(1, 0, 1, 1, 1, 0);
    step(1, 0, 1, 0, 1, 0);
    // R3 byte_addr change without start keeps length
    chk("R3 hold", short_len, 1);

    // R1 read/convert falls last, 12-bit
    exp_q.push_back(1'b0);
    step(1, 0, 0, 0, 1, 0);
    drained("R1 rdconv last");
    chk("R3 len 12", short_len, 0);
    step(1, 0, 1, 0, 1, 0);

    // R2 all three at once
    step(0, 1, 1, 1, 1, 0);
    exp_q.push_back(1'b1);
    step(1, 0, 0, 1, 1, 0);
    step(1, 0, 0, 1, 1, 0);
    drained("R2 single strobe");
    step(1, 0, 1, 1, 1, 0);

    // R4 start edge while busy: no strobe, length still captured
    step(1, 0, 1, 0, 1, 1);
    step(1, 0, 0, 0, 1, 1);
    drained("R4 no strobe");
    chk("R4 len captured", short_len, 0);
    step(1, 0, 1, 0, 1, 1);
    chk("R5 busy blocks read", data_oe, 0);

    // R6 wide read, byte_addr ignored
    step(1, 0, 1, 1, 1, 0);
    chk("R6 oe", data_oe, 12'hFFF);
    chk("R6 data", data_out, 12'hA5C);
    step(1, 0, 1, 0, 1, 0);
    chk("R6 a0 ignored", data_out, 12'hA5C);

    // R7 / R8 split reads
    step(1, 0, 1, 0, 0, 0);
    chk("R7 oe", data_oe, 12'hFF0);
    chk("R7 data", data_out, 12'hA50);
    step(1, 0, 1, 1, 0, 0);
    chk("R8 oe", data_oe, 12'hFF0);
    chk("R8 data", data_out, 12'hC00);

    // R5 gating by each line
    step(0, 0, 1, 1, 0, 0);
    chk("R5 enable low oe", data_oe, 0);
    chk("R5 enable low data", data_out, 0);
    step(1, 1, 1, 1, 0, 0);
    chk("R5 select high", data_oe, 0);
    exp_q.push_back(1'b1);
    step(1, 0, 0, 1, 0, 0);
    chk("R5 convert level", data_oe, 0);
    drained("R5 start on select");
    step(0, 1, 1, 0, 1, 0);

    // R10 latency: third rising edge
    word = 12'h3E7;
    drive(1, 0, 1, 0, 1, 0);
    @(negedge clk); chk("R10 edge1", data_oe, 0);
    @(negedge clk); chk("R10 edge2", data_oe, 0);
    @(negedge clk); chk("R10 edge3", data_oe, 12'hFFF);
    chk("R10 data", data_out, 12'h3E7);
    settle();

    // R9 stand-alone
    exp_q.push_back(1'b0);
    step(1, 0, 0, 0, 1, 0);
    drained("R9 start");
    chk("R9 len", short_len, 0);
    step(1, 0, 1, 0, 1, 1);
    chk("R9 busy no read", data_oe, 0);
    step(1, 0, 1, 0, 1, 0);
    chk("R9 read oe", data_oe, 12'hFFF);
    chk("R9 read data", data_out, 12'h3E7);

    drained("R1 final");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule